// File: doc/BRIEF.md
# Half-Bridge Protection Latch

This block holds the latched protection state of a resonant half-bridge lamp controller. It receives comparator results that are already digital: current sense above the programmable high threshold, current sense below the fixed low threshold, junction over-temperature, shutdown input high, and undervoltage lockout. It also receives two one-cycle strobes from the mode sequencer, one at the end of preheat and one at the start of run mode, and the low-side gate drive signal. It decides when each comparator may trip the latch. It then keeps a sticky fault flag, which the rest of the controller uses to stop the oscillator and pull both gate outputs low.

A two-bit cause code records which fault tripped first. It holds that value until the latch is released. The latch never releases on its own. Only a high shutdown input or an active undervoltage lockout clears it. While either of those is high, no fault can set the latch. The sequencer is expected to restart from preheat once shutdown has returned low. Every comparator input passes through a synchroniser before any decision uses it. Current sensing acts on each switching cycle individually, not on an averaged value.

Top module: `halfBridgeFaultLatch`

## Requirements
- R1: While reset is asserted, and from then until a fault trips, `faultLatched` is 0 and `faultCause` is 0 (the code for no fault).
- R2: The high current-sense flag has no effect until a `preheatEnd` strobe has been seen. After that strobe it sets the latch with cause code 01.
- R3: The low current-sense flag has no effect until a `runStart` strobe has been seen, even when `loGate` falls.
- R4: Once enabled, the low current-sense flag is evaluated only in a cycle where `loGate` has just fallen (it was 1 at the previous clock edge and is 0 at this one). It then sets the latch with cause code 10. The flag held high while `loGate` is steady or rising does nothing.
- R5: The over-temperature flag sets the latch with cause code 11 in any mode, including before the end of preheat.
- R6: Once set, the flag stays 1 and the cause code stays unchanged after the fault inputs drop, and also when a different fault arrives later.
- R7: A high shutdown input clears the flag and the cause code. While it stays high, no fault can set the latch.
- R8: An active undervoltage lockout input clears the flag and the cause code in the same way as shutdown.
- R9: When several enabled faults are present in the same cycle, the recorded cause follows the priority over-temperature (11), then high current (01), then low current (10).
- R10: Each comparator input crosses a two-stage synchroniser. A change applied before clock edge N is acted on at edge N+2, so outputs change after the third edge.
- R11: Clearing the latch also withdraws both current-sense enables, so new `preheatEnd` and `runStart` strobes are needed before either current trip can fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| csAboveHi | input | 1 | Current sense above programmable high threshold |
| csBelowLo | input | 1 | Current sense below fixed low threshold |
| overTemp | input | 1 | Junction over-temperature comparator |
| shutdownHigh | input | 1 | Shutdown input above its threshold |
| uvloActive | input | 1 | Undervoltage lockout asserted |
| preheatEnd | input | 1 | One-cycle strobe at end of preheat |
| runStart | input | 1 | One-cycle strobe at start of run mode |
| loGate | input | 1 | Low-side gate drive level |
| faultLatched | output | 1 | Sticky fault flag |
| faultCause | output | 2 | First fault cause: 00 none, 01 high current, 10 low current, 11 over-temperature |

## Verification
A lost or stuck current-sense enable shows at the ports in one of two ways. Either the flag sets while the enable should still be off, during preheat or before run mode, or the flag fails to set three edges after an enabled trip. A wrong edge detector on the low-side gate sets the flag during a steady-high gate period instead of on the cycle after the falling edge. A cause register that is wrongly updated shows as a changed code on the cycle after a second fault arrives. A clear that is missing or leaks shows within three edges of the shutdown or undervoltage input changing.

// File: rtl/halfBridgeFaultPkg.sv
package halfBridgeFaultPkg;

  typedef enum logic [1:0] {
    CAUSE_NONE          = 2'b00,
    CAUSE_OVER_CURRENT  = 2'b01,
    CAUSE_UNDER_CURRENT = 2'b10,
    CAUSE_OVER_TEMP     = 2'b11
  } faultCause_e;

  localparam int unsigned CAUSE_W = $bits(faultCause_e);

  // bit positions of the synchronised comparator vector
  localparam int unsigned FLAG_OC    = 0;
  localparam int unsigned FLAG_UC    = 1;
  localparam int unsigned FLAG_OT    = 2;
  localparam int unsigned FLAG_SD    = 3;
  localparam int unsigned FLAG_UV    = 4;
  localparam int unsigned FLAG_COUNT = 5;

  // strobes from control to the latch datapath
  typedef struct packed {
    logic clearReq;
    logic overTempTrip;
    logic overCurrentTrip;
    logic underCurrentTrip;
  } tripStrobes_t;

endpackage

// File: rtl/faultSync.sv
module faultSync #(
  parameter int unsigned WIDTH  = 5,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  localparam int unsigned LAST = STAGES - 1;

  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe[0] <= '0;
    else       pipe[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : gStage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe[s] <= '0;
      else       pipe[s] <= pipe[s-1];
    end
  end

  assign syncOut = pipe[LAST];

endmodule

// File: rtl/faultCtrl.sv
module faultCtrl
  import halfBridgeFaultPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FLAG_COUNT-1:0] syncFlags,
  input  logic                  preheatEnd,
  input  logic                  runStart,
  input  logic                  loGate,
  output tripStrobes_t          strobes
);
  logic ocEnable;
  logic ucEnable;
  logic loPrev;
  logic loFall;
  logic clearNow;

  assign clearNow = syncFlags[FLAG_SD] | syncFlags[FLAG_UV];
  assign loFall   = loPrev & ~loGate;

  // current-sense enables follow the mode sequence, withdrawn on clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ocEnable <= 1'b0;
      ucEnable <= 1'b0;
    end else if (clearNow) begin
      ocEnable <= 1'b0;
      ucEnable <= 1'b0;
    end else begin
      if (preheatEnd) ocEnable <= 1'b1;
      if (runStart)   ucEnable <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) loPrev <= 1'b0;
    else       loPrev <= loGate;
  end

  always_comb begin
    strobes                  = '0;
    strobes.clearReq         = clearNow;
    strobes.overTempTrip     = ~clearNow & syncFlags[FLAG_OT];
    strobes.overCurrentTrip  = ~clearNow & ocEnable & syncFlags[FLAG_OC];
    strobes.underCurrentTrip = ~clearNow & ucEnable & loFall & syncFlags[FLAG_UC];
  end

  // R11: a clear withdraws both enables on the next edge
  a_r11_enables_drop: assert property (@(posedge clk) disable iff (!rstN)
    clearNow |=> (!ocEnable && !ucEnable));

  // R3: no low-current trip without a run-start strobe since the last clear
  a_r3_uc_needs_run: assert property (@(posedge clk) disable iff (!rstN)
    (clearNow && !runStart) |=> !strobes.underCurrentTrip);

endmodule

// File: rtl/faultData.sv
module faultData
  import halfBridgeFaultPkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  tripStrobes_t       strobes,
  output logic               faultLatched,
  output logic [CAUSE_W-1:0] faultCause
);
  faultCause_e causeReg;
  faultCause_e causeNext;
  logic        latchReg;
  logic        anyTrip;

  assign anyTrip = strobes.overTempTrip | strobes.overCurrentTrip |
                   strobes.underCurrentTrip;

  always_comb begin
    if (strobes.overTempTrip)         causeNext = CAUSE_OVER_TEMP;
    else if (strobes.overCurrentTrip) causeNext = CAUSE_OVER_CURRENT;
    else if (strobes.underCurrentTrip) causeNext = CAUSE_UNDER_CURRENT;
    else                              causeNext = CAUSE_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      latchReg <= 1'b0;
      causeReg <= CAUSE_NONE;
    end else if (strobes.clearReq) begin
      latchReg <= 1'b0;
      causeReg <= CAUSE_NONE;
    end else if (!latchReg && anyTrip) begin
      latchReg <= 1'b1;
      causeReg <= causeNext;
    end
  end

  assign faultLatched = latchReg;
  assign faultCause   = causeReg;

  // R6: sticky flag and frozen cause until a clear
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (latchReg && !strobes.clearReq) |=> latchReg);
  a_r6_cause_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (latchReg && !strobes.clearReq) |=> $stable(causeReg));

  // R7 / R8: clear empties flag and cause
  a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearReq |=> (!latchReg && causeReg == CAUSE_NONE));

  // R1: flag and cause agree at all times
  a_r1_flag_cause_agree: assert property (@(posedge clk) disable iff (!rstN)
    latchReg == (causeReg != CAUSE_NONE));

  // R9: over-temperature wins a tie
  a_r9_temp_first: assert property (@(posedge clk) disable iff (!rstN)
    (!latchReg && strobes.overTempTrip) |=> causeReg == CAUSE_OVER_TEMP);

endmodule

// File: rtl/halfBridgeFaultLatch.sv
module halfBridgeFaultLatch
  import halfBridgeFaultPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csAboveHi,
  input  logic       csBelowLo,
  input  logic       overTemp,
  input  logic       shutdownHigh,
  input  logic       uvloActive,
  input  logic       preheatEnd,
  input  logic       runStart,
  input  logic       loGate,
  output logic       faultLatched,
  output logic [1:0] faultCause
);
  logic [FLAG_COUNT-1:0] rawFlags;
  logic [FLAG_COUNT-1:0] syncFlags;
  tripStrobes_t          strobes;

  always_comb begin
    rawFlags          = '0;
    rawFlags[FLAG_OC] = csAboveHi;
    rawFlags[FLAG_UC] = csBelowLo;
    rawFlags[FLAG_OT] = overTemp;
    rawFlags[FLAG_SD] = shutdownHigh;
    rawFlags[FLAG_UV] = uvloActive;
  end

  faultSync #(.WIDTH(FLAG_COUNT), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rstN    (rstN),
    .asyncIn (rawFlags),
    .syncOut (syncFlags)
  );

  faultCtrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .syncFlags  (syncFlags),
    .preheatEnd (preheatEnd),
    .runStart   (runStart),
    .loGate     (loGate),
    .strobes    (strobes)
  );

  faultData u_data (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .faultLatched (faultLatched),
    .faultCause   (faultCause)
  );

  // R4: a low-current fault appears only right after a low-side falling edge
  a_r4_uc_on_lo_fall: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(faultLatched) && faultCause == CAUSE_UNDER_CURRENT)
      |-> ($past(loGate, 2) && !$past(loGate, 1)));

endmodule

// File: tb/halfBridgeFaultLatch_tb.sv
module halfBridgeFaultLatch_tb;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic csAboveHi = 0, csBelowLo = 0, overTemp = 0, shutdownHigh = 0;
  logic uvloActive = 0, preheatEnd = 0, runStart = 0, loGate = 0;
  logic       faultLatched;
  logic [1:0] faultCause;

  typedef struct {
    logic       fault;
    logic [1:0] cause;
    string      tag;
  } expItem_t;

  expItem_t scoreQ[$];
  int checkCount = 0;
  int failCount  = 0;
  bit finished   = 0;

  always #10 clk = ~clk;

  halfBridgeFaultLatch u_dut (
    .clk(clk), .rstN(rstN), .csAboveHi(csAboveHi), .csBelowLo(csBelowLo),
    .overTemp(overTemp), .shutdownHigh(shutdownHigh), .uvloActive(uvloActive),
    .preheatEnd(preheatEnd), .runStart(runStart), .loGate(loGate),
    .faultLatched(faultLatched), .faultCause(faultCause)
  );

  // monitor: compare after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (scoreQ.size() > 0) begin
        expItem_t e;
        e = scoreQ.pop_front();
        checkCount++;
        if (faultLatched !== e.fault || faultCause !== e.cause) begin
          failCount++;
          $display("FAIL %s: got fault=%0b cause=%0d, expected fault=%0b cause=%0d",
                   e.tag, faultLatched, faultCause, e.fault, e.cause);
        end
      end
    end
  end

  // driver: push the expectation for the next edge, then wait one cycle
  task automatic cyc(input logic f, input logic [1:0] c, input string tag);
    expItem_t e;
    e.fault = f; e.cause = c; e.tag = tag;
    scoreQ.push_back(e);
    @(negedge clk);
  endtask

  task automatic idle(input int n, input logic f, input logic [1:0] c, input string tag);
    for (int i = 0; i < n; i++) cyc(f, c, tag);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCount - failCount, checkCount);
    $finish;
  endtask

  initial begin
    #(20 * 20000);
    if (!finished) begin
      checkCount++;
      failCount++;
      $display("FAIL watchdog: got hung run, expected completion");
      summary();
    end
  end

  initial begin
    @(negedge clk);
    idle(3, 1'b0, 2'd0, "R1 reset");
    rstN = 1'b1;
    idle(2, 1'b0, 2'd0, "R1 idle");

    // R2: high current ignored during preheat
    csAboveHi = 1; idle(6, 1'b0, 2'd0, "R2 ignored in preheat");
    csAboveHi = 0; idle(3, 1'b0, 2'd0, "R2 ignored in preheat");

    // R3: low current ignored before run even with lo falling
    csBelowLo = 1; idle(3, 1'b0, 2'd0, "R3 before run");
    loGate = 1; cyc(1'b0, 2'd0, "R3 before run");
    loGate = 0; idle(3, 1'b0, 2'd0, "R3 lo fall before run");
    csBelowLo = 0; idle(3, 1'b0, 2'd0, "R3 before run");

    // R5 / R10: over-temp before preheat end, three-edge latency
    overTemp = 1;
    idle(2, 1'b0, 2'd0, "R10 not yet");
    cyc(1'b1, 2'd3, "R5 over-temp trips");
    overTemp = 0; idle(4, 1'b1, 2'd3, "R6 sticky after drop");

    // R7: shutdown clears and holds clear
    shutdownHigh = 1;
    idle(2, 1'b1, 2'd3, "R7 before clear");
    cyc(1'b0, 2'd0, "R7 cleared");
    overTemp = 1; idle(4, 1'b0, 2'd0, "R7 held clear");
    overTemp = 0; idle(3, 1'b0, 2'd0, "R7 held clear");
    shutdownHigh = 0; idle(3, 1'b0, 2'd0, "R7 released");

    // R2: enabled after preheat end
    preheatEnd = 1; cyc(1'b0, 2'd0, "R2 strobe");
    preheatEnd = 0;
    csAboveHi = 1;
    idle(2, 1'b0, 2'd0, "R2 latency");
    cyc(1'b1, 2'd1, "R2 over-current trips");
    csAboveHi = 0;
    overTemp = 1; idle(5, 1'b1, 2'd1, "R6 cause kept on later fault");
    overTemp = 0; idle(3, 1'b1, 2'd1, "R6 cause kept");

    // R8: undervoltage clears
    uvloActive = 1;
    idle(2, 1'b1, 2'd1, "R8 before clear");
    cyc(1'b0, 2'd0, "R8 cleared");
    uvloActive = 0; idle(3, 1'b0, 2'd0, "R8 released");

    // R11: enables withdrawn by the clear
    csAboveHi = 1; idle(5, 1'b0, 2'd0, "R11 over-current disabled after clear");
    csAboveHi = 0; idle(3, 1'b0, 2'd0, "R11");

    // R3 / R4: low current after run start, only on lo falling edge
    preheatEnd = 1; cyc(1'b0, 2'd0, "R4 setup");
    preheatEnd = 0; runStart = 1; cyc(1'b0, 2'd0, "R4 setup");
    runStart = 0;
    csBelowLo = 1; idle(4, 1'b0, 2'd0, "R4 lo steady low");
    loGate = 1; cyc(1'b0, 2'd0, "R4 lo rising");
    cyc(1'b0, 2'd0, "R4 lo steady high");
    loGate = 0; cyc(1'b1, 2'd2, "R4 trip on lo fall");
    csBelowLo = 0; idle(3, 1'b1, 2'd2, "R6 sticky");

    shutdownHigh = 1;
    idle(2, 1'b1, 2'd2, "R7 before clear");
    cyc(1'b0, 2'd0, "R7 cleared");
    shutdownHigh = 0; idle(3, 1'b0, 2'd0, "R7 released");

    // R9: over-temp beats over-current
    preheatEnd = 1; cyc(1'b0, 2'd0, "R9 setup");
    preheatEnd = 0; runStart = 1; cyc(1'b0, 2'd0, "R9 setup");
    runStart = 0;
    csAboveHi = 1; overTemp = 1;
    idle(2, 1'b0, 2'd0, "R9 latency");
    cyc(1'b1, 2'd3, "R9 over-temp first");
    csAboveHi = 0; overTemp = 0;
    shutdownHigh = 1;
    idle(2, 1'b1, 2'd3, "R9 before clear");
    cyc(1'b0, 2'd0, "R7 cleared");
    shutdownHigh = 0; idle(3, 1'b0, 2'd0, "R7 released");

    // R9: over-current beats under-current
    preheatEnd = 1; cyc(1'b0, 2'd0, "R9 setup");
    preheatEnd = 0; runStart = 1; cyc(1'b0, 2'd0, "R9 setup");
    runStart = 0;
    csBelowLo = 1; idle(3, 1'b0, 2'd0, "R9 setup");
    loGate = 1; csAboveHi = 1;
    idle(2, 1'b0, 2'd0, "R9 latency");
    loGate = 0; cyc(1'b1, 2'd1, "R9 over-current before under-current");
    csAboveHi = 0; csBelowLo = 0;
    idle(2, 1'b1, 2'd1, "R6 sticky");

    @(posedge clk);
    #8;
    finished = 1;
    summary();
  end
endmodule